// File: doc/BRIEF.md
# Lamp Ballast Sequencer

This block sequences a resonant lamp ballast through four operating phases: supply start-up, ignition, burn and a latched power-down. Comparators outside the block turn every analog condition into a flag: the supply level against the start, stop and reset thresholds, the lamp voltage against the fail and maximum thresholds, the oscillator reaching its lowest frequency, and the current loop taking over. From these flags the block drives the oscillator enable, the current-sensor enable and a two-bit command that tells the analog frequency generator what to do.

Ignition starts at the highest frequency and sweeps downward. An ignition window timer runs inside the block. It starts only when the lamp voltage first goes above the fail level, and it decides whether the lamp has struck. A lamp that is still above the fail level when the window closes leads to a latched power-down. Only a deep supply collapse releases this power-down. If the lamp fails during burn, the block goes back to ignition once and opens a fresh window. A capacitive-mode event sends the frequency back to maximum without any change of phase.

Top module: `ballast_ctrl`

## Requirements
- R1: While rstN is low, lampState is 0 (start-up), and oscEnable, curSenseEnable, freqRestart and timerActive are all 0. freqMode is 0 (off).
- R2: In start-up, if supplyAboveStart is 1 and supplyBelowStop is 0 at a clock edge, then after that edge lampState is 1 (ignition) and oscEnable is 1. freqRestart is 1 for exactly that one cycle.
- R3: In ignition or burn, supplyBelowStop at an edge returns lampState to 0 and clears oscEnable and curSenseEnable. In start-up the state holds while supplyAboveStart is 0.
- R4: In ignition, freqMode is 1 (sweep down). It is 2 (hold) while lampAboveMax is 1.
- R5: timerActive stays 0 in ignition until lampAboveFail is sampled high. It is 0 in every phase other than ignition.
- R6: After lampAboveFail is sampled high in ignition, timerActive is 1 for exactly WINDOW_TICKS cycles. If lampAboveFail is 1 at the closing edge, lampState becomes 3 (power-down), with oscEnable 0 and freqMode 0.
- R7: If lampAboveFail is 0 when the window closes, timerActive returns to 0 and the block stays in ignition.
- R8: In ignition, freqAtMin moves lampState to 2 (burn), but only once no window is running; while a window runs, the block stays in ignition. In burn, curSenseEnable is 1, and freqMode is 2 (hold) or 3 (current loop) when loopEngaged is 1.
- R9: In burn, lampAboveFail at an edge puts the block back into ignition. freqRestart pulses, and a new window starts on the same edge. If the lamp is still high when that window closes, the block enters power-down.
- R10: In power-down, supplyAboveStart and supplyBelowStop have no effect. Only supplyBelowReset returns lampState to 0.
- R11: capModeEvt sampled in ignition or burn gives a one-cycle freqRestart pulse and leaves lampState unchanged. In start-up or power-down it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyAboveStart | input | 1 | Supply is above the start threshold |
| supplyBelowStop | input | 1 | Supply is below the stop threshold |
| supplyBelowReset | input | 1 | Supply is below the deep reset threshold |
| lampAboveFail | input | 1 | Lamp voltage is above the fail level (hysteresis applied outside) |
| lampAboveMax | input | 1 | Lamp voltage is at its clamp level |
| freqAtMin | input | 1 | Oscillator has reached its lowest frequency |
| loopEngaged | input | 1 | Average-current loop is regulating |
| capModeEvt | input | 1 | Capacitive switching detected |
| lampState | output | 2 | 0 start-up, 1 ignition, 2 burn, 3 power-down |
| oscEnable | output | 1 | Half-bridge oscillator runs |
| curSenseEnable | output | 1 | Current sensor is enabled |
| freqMode | output | 2 | 0 off, 1 sweep down, 2 hold, 3 current loop |
| freqRestart | output | 1 | One-cycle strobe: reset the frequency to maximum |
| timerActive | output | 1 | Ignition window is running |

## Verification
A phase change and the freqRestart strobe appear right after the edge that samples the input causing them. freqMode follows lampAboveMax and loopEngaged in the same cycle. The window count covers the WINDOW_TICKS cycles after the arming edge, and the closing edge makes the decision. The bench drives inputs one time unit after a rising edge and reads outputs after the next rising edge. For same-cycle freqMode checks, it waits one time unit after changing the input. The window length is counted sample by sample from the arming edge, and the bench compares that count with the WINDOW_TICKS it passes to the block.

// File: rtl/ballast_ctrl_pkg.sv
package ballast_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_STARTUP = 2'd0,
    ST_IGNITE  = 2'd1,
    ST_BURN    = 2'd2,
    ST_PWRDN   = 2'd3
  } lampState_e;

  typedef enum logic [1:0] {
    FM_OFF   = 2'd0,
    FM_SWEEP = 2'd1,
    FM_HOLD  = 2'd2,
    FM_LOOP  = 2'd3
  } freqMode_e;

  // strobes from sequencer to the timer/restart datapath
  typedef struct packed {
    logic timerEnable;
    logic timerStart;
    logic restartReq;
  } dpCtrl_t;

endpackage

// File: rtl/ballast_timer_dp.sv
module ballast_timer_dp
  import ballast_ctrl_pkg::*;
#(
  parameter int WINDOW_TICKS = 51_400_000,
  parameter int CNT_W        = $clog2(WINDOW_TICKS)
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctrl,
  output logic    timerDone,
  output logic    timerActive,
  output logic    freqRestart
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WINDOW_TICKS - 1);

  logic             armedQ;
  logic [CNT_W-1:0] cntQ;
  logic             restartQ;

  assign timerDone   = armedQ && (cntQ == LAST_TICK);
  assign timerActive = armedQ;
  assign freqRestart = restartQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ   <= 1'b0;
      cntQ     <= '0;
      restartQ <= 1'b0;
    end else begin
      restartQ <= ctrl.restartReq;
      if (!ctrl.timerEnable || timerDone) begin
        armedQ <= 1'b0;
        cntQ   <= '0;
      end else if (armedQ) begin
        cntQ <= cntQ + 1'b1;
      end else if (ctrl.timerStart) begin
        armedQ <= 1'b1;
        cntQ   <= '0;
      end
    end
  end

  // R5
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.timerEnable |=> !timerActive);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerDone |=> !timerDone);

  // R11
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restartReq |=> freqRestart);

endmodule

// File: rtl/ballast_seq_fsm.sv
module ballast_seq_fsm
  import ballast_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyAboveStart,
  input  logic       supplyBelowStop,
  input  logic       supplyBelowReset,
  input  logic       lampAboveFail,
  input  logic       lampAboveMax,
  input  logic       freqAtMin,
  input  logic       loopEngaged,
  input  logic       capModeEvt,
  input  logic       timerDone,
  input  logic       timerActive,
  output lampState_e stateQ,
  output dpCtrl_t    ctrl,
  output logic       oscEnable,
  output logic       curSenseEnable,
  output freqMode_e  freqMode
);

  lampState_e nextState;
  logic       oscPhase;
  logic       nextOscPhase;

  always_comb begin
    nextState = stateQ;
    unique case (stateQ)
      ST_STARTUP: if (supplyAboveStart && !supplyBelowStop) nextState = ST_IGNITE;
      ST_IGNITE: begin
        if (supplyBelowStop)                           nextState = ST_STARTUP;
        else if (timerDone && lampAboveFail)           nextState = ST_PWRDN;
        else if (freqAtMin && (!timerActive || timerDone)) nextState = ST_BURN;
      end
      ST_BURN: begin
        if (supplyBelowStop)    nextState = ST_STARTUP;
        else if (lampAboveFail) nextState = ST_IGNITE;
      end
      ST_PWRDN: if (supplyBelowReset) nextState = ST_STARTUP;
      default: nextState = ST_STARTUP;
    endcase
  end

  assign oscPhase     = (stateQ == ST_IGNITE) || (stateQ == ST_BURN);
  assign nextOscPhase = (nextState == ST_IGNITE) || (nextState == ST_BURN);

  always_comb begin
    ctrl.timerEnable = (nextState == ST_IGNITE);
    ctrl.timerStart  = lampAboveFail && (nextState == ST_IGNITE);
    ctrl.restartReq  = ((nextState == ST_IGNITE) && (stateQ != ST_IGNITE)) ||
                       (capModeEvt && oscPhase && nextOscPhase);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_STARTUP;
    else       stateQ <= nextState;
  end

  assign oscEnable      = oscPhase;
  assign curSenseEnable = (stateQ == ST_BURN);

  always_comb begin
    unique case (stateQ)
      ST_IGNITE: freqMode = lampAboveMax ? FM_HOLD : FM_SWEEP;
      ST_BURN:   freqMode = loopEngaged  ? FM_LOOP : FM_HOLD;
      default:   freqMode = FM_OFF;
    endcase
  end

  // R10
  pd_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PWRDN && !supplyBelowReset) |=> (stateQ == ST_PWRDN));

  // R6
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IGNITE && timerDone && lampAboveFail && !supplyBelowStop)
      |=> (stateQ == ST_PWRDN));

  // R3
  uvlo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oscPhase && supplyBelowStop) |=> (stateQ == ST_STARTUP));

  // R11
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BURN && capModeEvt && !supplyBelowStop && !lampAboveFail)
      |=> (stateQ == ST_BURN));

endmodule

// File: rtl/ballast_ctrl.sv
module ballast_ctrl
  import ballast_ctrl_pkg::*;
#(
  parameter int WINDOW_TICKS = 51_400_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyAboveStart,
  input  logic       supplyBelowStop,
  input  logic       supplyBelowReset,
  input  logic       lampAboveFail,
  input  logic       lampAboveMax,
  input  logic       freqAtMin,
  input  logic       loopEngaged,
  input  logic       capModeEvt,
  output logic [1:0] lampState,
  output logic       oscEnable,
  output logic       curSenseEnable,
  output logic [1:0] freqMode,
  output logic       freqRestart,
  output logic       timerActive
);

  localparam int CNT_W = (WINDOW_TICKS > 2) ? $clog2(WINDOW_TICKS) : 1;

  lampState_e stateQ;
  freqMode_e  modeSel;
  dpCtrl_t    ctrl;
  logic       timerDone;

  ballast_seq_fsm u_fsm (
    .clk              (clk),
    .rstN             (rstN),
    .supplyAboveStart (supplyAboveStart),
    .supplyBelowStop  (supplyBelowStop),
    .supplyBelowReset (supplyBelowReset),
    .lampAboveFail    (lampAboveFail),
    .lampAboveMax     (lampAboveMax),
    .freqAtMin        (freqAtMin),
    .loopEngaged      (loopEngaged),
    .capModeEvt       (capModeEvt),
    .timerDone        (timerDone),
    .timerActive      (timerActive),
    .stateQ           (stateQ),
    .ctrl             (ctrl),
    .oscEnable        (oscEnable),
    .curSenseEnable   (curSenseEnable),
    .freqMode         (modeSel)
  );

  ballast_timer_dp #(
    .WINDOW_TICKS (WINDOW_TICKS),
    .CNT_W        (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .timerDone   (timerDone),
    .timerActive (timerActive),
    .freqRestart (freqRestart)
  );

  assign lampState = stateQ;
  assign freqMode  = modeSel;

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEnable) |-> freqRestart);

  // R8
  sense_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    curSenseEnable |-> !timerActive);

endmodule

// File: tb/test_ballast_ctrl.sv
`timescale 1ns/1ps
module test_ballast_ctrl;

  localparam int WIN = 20;

  logic clk = 1'b0;
  logic rstN;
  logic supplyAboveStart, supplyBelowStop, supplyBelowReset;
  logic lampAboveFail, lampAboveMax, freqAtMin, loopEngaged, capModeEvt;
  logic [1:0] lampState, freqMode;
  logic oscEnable, curSenseEnable, freqRestart, timerActive;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  ballast_ctrl #(.WINDOW_TICKS(WIN)) i_ballast_ctrl (
    .clk(clk), .rstN(rstN),
    .supplyAboveStart(supplyAboveStart), .supplyBelowStop(supplyBelowStop),
    .supplyBelowReset(supplyBelowReset), .lampAboveFail(lampAboveFail),
    .lampAboveMax(lampAboveMax), .freqAtMin(freqAtMin),
    .loopEngaged(loopEngaged), .capModeEvt(capModeEvt),
    .lampState(lampState), .oscEnable(oscEnable),
    .curSenseEnable(curSenseEnable), .freqMode(freqMode),
    .freqRestart(freqRestart), .timerActive(timerActive)
  );

  task automatic chk(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    supplyAboveStart = 0; supplyBelowStop = 0; supplyBelowReset = 0;
    lampAboveFail = 0; lampAboveMax = 0; freqAtMin = 0;
    loopEngaged = 0; capModeEvt = 0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic goIgnite();
    applyReset();
    supplyAboveStart = 1;
    step();
  endtask

  task automatic goBurn();
    goIgnite();
    freqAtMin = 1;
    step();
  endtask

  task automatic tReset();
    rstN = 1'b0;
    supplyAboveStart = 1; lampAboveFail = 1; capModeEvt = 1;
    step(); step();
    chk(lampState, 0, "R1 state");
    chk(oscEnable, 0, "R1 osc");
    chk(curSenseEnable, 0, "R1 sense");
    chk(freqMode, 0, "R1 mode");
    chk(freqRestart, 0, "R1 restart");
    chk(timerActive, 0, "R1 timer");
  endtask

  task automatic tStartup();
    applyReset();
    step(); step(); step();
    chk(lampState, 0, "R3 hold startup");
    supplyAboveStart = 1;
    step();
    chk(lampState, 1, "R2 enter ignite");
    chk(oscEnable, 1, "R2 osc");
    chk(freqRestart, 1, "R2 restart pulse");
    step();
    chk(freqRestart, 0, "R2 restart one cycle");
  endtask

  task automatic tSweep();
    goIgnite();
    chk(freqMode, 1, "R4 sweep");
    lampAboveMax = 1; #1;
    chk(freqMode, 2, "R4 hold at max");
    lampAboveMax = 0; #1;
    chk(freqMode, 1, "R4 sweep again");
  endtask

  task automatic tTimerPd();
    int act = 0;
    int pdAt = -1;
    goIgnite();
    step(); step(); step();
    chk(timerActive, 0, "R5 idle before fail");
    lampAboveFail = 1;
    for (int i = 0; i < WIN + 4; i++) begin
      step();
      if (timerActive) act++;
      if (lampState == 3 && pdAt < 0) pdAt = i;
    end
    chk(act, WIN, "R6 window length");
    chk(pdAt, WIN, "R6 pd at window end");
    chk(oscEnable, 0, "R6 osc off");
    chk(freqMode, 0, "R6 mode off");
    chk(timerActive, 0, "R5 cleared in pd");
  endtask

  task automatic tTimerOk();
    goIgnite();
    lampAboveFail = 1;
    step();
    chk(timerActive, 1, "R5 armed");
    lampAboveFail = 0;
    for (int i = 0; i < WIN + 2; i++) step();
    chk(timerActive, 0, "R7 window closed");
    chk(lampState, 1, "R7 stays ignite");
  endtask

  task automatic tBurn();
    goIgnite();
    lampAboveFail = 1;
    step();
    lampAboveFail = 0;
    freqAtMin = 1;
    step(); step();
    chk(lampState, 1, "R8 no burn while window runs");
    for (int i = 0; i < WIN; i++) step();
    chk(lampState, 2, "R8 burn after window");
    goBurn();
    chk(lampState, 2, "R8 burn on min");
    chk(curSenseEnable, 1, "R8 sense on");
    chk(freqMode, 2, "R8 hold");
    loopEngaged = 1; #1;
    chk(freqMode, 3, "R8 loop");
  endtask

  task automatic tReignite();
    goBurn();
    lampAboveFail = 1;
    step();
    chk(lampState, 1, "R9 back to ignite");
    chk(freqRestart, 1, "R9 restart");
    chk(timerActive, 1, "R9 window armed");
    chk(curSenseEnable, 0, "R9 sense off");
    for (int i = 0; i < WIN; i++) step();
    chk(lampState, 3, "R9 pd after retry");
  endtask

  task automatic tPdLatch();
    goIgnite();
    lampAboveFail = 1;
    for (int i = 0; i < WIN + 1; i++) step();
    chk(lampState, 3, "R10 in pd");
    supplyBelowStop = 1; step();
    supplyBelowStop = 0; supplyAboveStart = 1; step();
    capModeEvt = 1; step();
    chk(lampState, 3, "R10 supply ignored");
    chk(freqRestart, 0, "R11 cap ignored in pd");
    chk(oscEnable, 0, "R10 osc off");
    capModeEvt = 0;
    supplyBelowReset = 1; supplyAboveStart = 0;
    step();
    chk(lampState, 0, "R10 released by reset level");
    supplyBelowReset = 0; supplyAboveStart = 1; lampAboveFail = 0;
    step();
    chk(lampState, 1, "R10 restart after release");
  endtask

  task automatic tUvlo();
    goBurn();
    supplyBelowStop = 1;
    step();
    chk(lampState, 0, "R3 uvlo from burn");
    chk(oscEnable, 0, "R3 osc off");
    chk(curSenseEnable, 0, "R3 sense off");
    goIgnite();
    supplyBelowStop = 1;
    step();
    chk(lampState, 0, "R3 uvlo from ignite");
  endtask

  task automatic tCap();
    goBurn();
    step();
    capModeEvt = 1;
    step();
    chk(freqRestart, 1, "R11 restart in burn");
    chk(lampState, 2, "R11 state kept");
    capModeEvt = 0;
    step();
    chk(freqRestart, 0, "R11 one cycle");
    applyReset();
    capModeEvt = 1;
    step();
    chk(freqRestart, 0, "R11 ignored in startup");
    chk(lampState, 0, "R11 startup kept");
    capModeEvt = 0;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #1;
    tReset();
    tStartup();
    tSweep();
    tTimerPd();
    tTimerOk();
    tBurn();
    tReignite();
    tPdLatch();
    tUvlo();
    tCap();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule